// File: doc/BRIEF.md
# Reloading Source-Pointer DMA Channel

This block is one memory-to-memory DMA channel that uses two addresses per transfer. Each transfer reads one element from the source pointer and then writes that element to a fixed destination address. After the write, the source pointer moves forward by the element size and a down-counter of remaining transfers drops by one. Software sets the channel up through a small register-write port. The memory side is a request/acknowledge handshake: the channel holds each read or write request until memory acknowledges it.

When reload mode is on, the channel counts transfers in groups of four. After the fourth transfer of a group, the source pointer returns to the value software last wrote into the source register. A four-element source table is therefore streamed to the destination again and again. The group counter is separate from the transfer count.

Several events abort the channel:
- any register write,
- a non-maskable interrupt,
- an address error, reported either by memory or found by the channel's own alignment check.

An abort cancels the transfer in flight and restarts the group counter. It leaves the source pointer, the destination and the remaining count as they were. Finishing the count, or an address error, raises a sticky end flag. That flag stops the channel until software clears it.

Top module: `dma_reload_channel`

## Requirements
- R1: After reset the channel issues no memory request and the end flag `xfer_end` is low. The master enable and the channel enable are both off.
- R2: Each transfer is a read request (`mem_we`=0) at the source pointer, then a write request (`mem_we`=1) at the destination carrying the data just read. Each request and its address stay asserted until `mem_ack`.
- R3: The size code is control bits [3:2]: 0 = byte, 1 = 16-bit, 2 or 3 = 32-bit. After each transfer the source pointer advances by 1, 2 or 4, and the destination address never changes. `mem_size` shows the size code.
- R4: With reload on (control bit 1), after every fourth completed transfer the source pointer returns to the value last written to the source register (select 0).
- R5: The count (select 2) drops by one per transfer whether or not reload is on. The transfer that takes it to zero sets `xfer_end`, and no further request follows. With reload on and a count that is not a multiple of four, the channel simply stops at zero.
- R6: `xfer_end` stays high until a control write (select 3) with bit 4 set. Other writes leave it high, and no request is issued while it is high.
- R7: The channel will not start a transfer if the source or destination address is misaligned for the size (odd for 16-bit, low two bits non-zero for 32-bit). Instead it sets `xfer_end` and issues no request.
- R8: `addr_err` asserted while a request is pending cancels that transfer, sets `xfer_end`, and leaves the count unchanged.
- R9: Any register write or `nmi` cancels a pending request and restarts the group of four. `nmi` also clears the master enable (select 4, bit 0), so no request follows until it is rewritten. Clearing the channel enable (control bit 0) also halts the channel.
- R10: Aborts change none of the source pointer, destination and count. After a restart the channel continues from the current pointer with the remaining count, and the next reload happens four transfers after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 source, 1 destination, 2 count, 3 control, 4 master enable |
| cfg_wdata | input | AW | Register write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | AW | Memory address |
| mem_size | output | 2 | Size code of the transfer |
| mem_wdata | output | DW | Write data (buffered read data) |
| mem_ack | input | 1 | Memory acknowledge, completes the pending request |
| mem_rdata | input | DW | Read data, valid with `mem_ack` on a read |
| nmi | input | 1 | Non-maskable interrupt, aborts the channel |
| addr_err | input | 1 | Address error reported by memory for the pending request |
| xfer_end | output | 1 | Sticky transfer-end flag |

## Verification
The hardest situation to reach from the ports is an abort that lands at a chosen point: part-way through a group of four, and in a known phase of the read/write pair. Only then does the restart show that the group counter was cleared while the pointer and count were kept. The bench runs the channel to a target number of completed transfers, then withholds `mem_ack` so the channel stays parked in the read or write phase. It then injects `addr_err`, `nmi` or a channel-enable clear, and restarts. After each restart its reference model predicts the address sequence, including where the reload now falls.

// File: rtl/dmarl_pkg.sv
package dmarl_pkg;

    typedef enum logic [1:0] {
        XSZ_BYTE = 2'd0,
        XSZ_HALF = 2'd1,
        XSZ_WORD = 2'd2,
        XSZ_WALT = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    localparam logic [2:0] SEL_SRC    = 3'd0;
    localparam logic [2:0] SEL_DST    = 3'd1;
    localparam logic [2:0] SEL_CNT    = 3'd2;
    localparam logic [2:0] SEL_CTRL   = 3'd3;
    localparam logic [2:0] SEL_MASTER = 3'd4;

    localparam int CTRL_BITS = 5;

    // Byte distance between consecutive source elements.
    function automatic logic [2:0] step_bytes(input xfer_size_e s);
        case (s)
            XSZ_BYTE: return 3'd1;
            XSZ_HALF: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

    // Low address bits that must be zero for the given size.
    function automatic logic [1:0] align_mask(input xfer_size_e s);
        case (s)
            XSZ_BYTE: return 2'b00;
            XSZ_HALF: return 2'b01;
            default:  return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/dmarl_cfg.sv
module dmarl_cfg
    import dmarl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_sel,
    input  logic [CTRL_BITS-1:0] ctrl_bits,
    input  logic                 nmi_i,
    input  logic                 te_set_i,
    output logic                 master_o,
    output logic                 chan_o,
    output logic                 reload_o,
    output xfer_size_e           size_o,
    output logic                 te_o,
    output logic                 src_wr_o,
    output logic                 dst_wr_o,
    output logic                 cnt_wr_o,
    output logic                 abort_o
);

    typedef struct packed {
        logic       master;
        logic       chan;
        logic       reload;
        xfer_size_e size;
        logic       te;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d    = cfg_q;
        src_wr_o = cfg_we && (cfg_sel == SEL_SRC);
        dst_wr_o = cfg_we && (cfg_sel == SEL_DST);
        cnt_wr_o = cfg_we && (cfg_sel == SEL_CNT);
        // Every register write and every NMI cancels an in-flight transfer.
        abort_o  = nmi_i || cfg_we;

        if (cfg_we && (cfg_sel == SEL_CTRL)) begin
            cfg_d.chan   = ctrl_bits[0];
            cfg_d.reload = ctrl_bits[1];
            cfg_d.size   = xfer_size_e'(ctrl_bits[3:2]);
            if (ctrl_bits[4]) begin
                cfg_d.te = 1'b0;
            end
        end
        if (cfg_we && (cfg_sel == SEL_MASTER)) begin
            cfg_d.master = ctrl_bits[0];
        end
        if (nmi_i) begin
            cfg_d.master = 1'b0;
        end
        if (te_set_i) begin
            cfg_d.te = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{master: 1'b0, chan: 1'b0, reload: 1'b0, size: XSZ_BYTE, te: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign master_o = cfg_q.master;
    assign chan_o   = cfg_q.chan;
    assign reload_o = cfg_q.reload;
    assign size_o   = cfg_q.size;
    assign te_o     = cfg_q.te;

endmodule

// File: rtl/dmarl_align.sv
module dmarl_align
    import dmarl_pkg::*;
(
    input  logic [1:0] src_lo,
    input  logic [1:0] dst_lo,
    input  xfer_size_e size_i,
    output logic       misaligned_o
);

    logic [1:0] mask;

    always_comb begin
        mask         = align_mask(size_i);
        misaligned_o = |((src_lo | dst_lo) & mask);
    end

endmodule

// File: rtl/dmarl_seq.sv
module dmarl_seq
    import dmarl_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int CW        = 16,
    parameter int GROUP_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_i,
    input  logic          chan_i,
    input  logic          reload_i,
    input  xfer_size_e    size_i,
    input  logic          te_i,
    input  logic          src_wr_i,
    input  logic          dst_wr_i,
    input  logic          cnt_wr_i,
    input  logic [AW-1:0] wdata_i,
    input  logic          abort_i,
    input  logic          aerr_i,
    input  logic          misaligned_i,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic [1:0]    ptr_lo_o,
    output logic [1:0]    dst_lo_o,
    output logic          te_set_o
);

    localparam int GW = $clog2(GROUP_LEN);
    localparam logic [GW-1:0] GRP_LAST = GW'(GROUP_LEN - 1);

    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] ptr;
        logic [AW-1:0] saved;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [GW-1:0] grp;
        logic [DW-1:0] data;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       go;
    logic [AW-1:0] step;

    always_comb begin
        st_d     = st_q;
        te_set_o = 1'b0;
        step     = AW'(step_bytes(size_i));
        go       = master_i && chan_i && !te_i && (st_q.cnt != '0);

        if (src_wr_i) begin
            st_d.ptr   = wdata_i;
            st_d.saved = wdata_i;
        end
        if (dst_wr_i) begin
            st_d.dst = wdata_i;
        end
        if (cnt_wr_i) begin
            st_d.cnt = wdata_i[CW-1:0];
        end

        if (abort_i) begin
            st_d.phase = PH_IDLE;
            st_d.grp   = '0;
        end else begin
            case (st_q.phase)
                PH_IDLE: begin
                    if (go) begin
                        if (misaligned_i) begin
                            te_set_o  = 1'b1;
                            st_d.grp  = '0;
                        end else begin
                            st_d.phase = PH_READ;
                        end
                    end
                end
                PH_READ: begin
                    if (aerr_i) begin
                        te_set_o   = 1'b1;
                        st_d.phase = PH_IDLE;
                        st_d.grp   = '0;
                    end else if (mem_ack_i) begin
                        st_d.data  = mem_rdata_i;
                        st_d.phase = PH_WRITE;
                    end
                end
                PH_WRITE: begin
                    if (aerr_i) begin
                        te_set_o   = 1'b1;
                        st_d.phase = PH_IDLE;
                        st_d.grp   = '0;
                    end else if (mem_ack_i) begin
                        st_d.cnt   = st_q.cnt - CW'(1);
                        st_d.phase = PH_IDLE;
                        if (reload_i && (st_q.grp == GRP_LAST)) begin
                            st_d.ptr = st_q.saved;
                            st_d.grp = '0;
                        end else begin
                            st_d.ptr = st_q.ptr + step;
                            st_d.grp = st_q.grp + GW'(1);
                        end
                        if (st_q.cnt == CW'(1)) begin
                            te_set_o = 1'b1;
                            st_d.grp = '0;
                        end
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, ptr: '0, saved: '0, dst: '0,
                      cnt: '0, grp: '0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req_o   = (st_q.phase != PH_IDLE);
    assign mem_we_o    = (st_q.phase == PH_WRITE);
    assign mem_addr_o  = (st_q.phase == PH_WRITE) ? st_q.dst : st_q.ptr;
    assign mem_wdata_o = st_q.data;
    assign ptr_lo_o    = st_q.ptr[1:0];
    assign dst_lo_o    = st_q.dst[1:0];

endmodule

// File: rtl/dma_reload_channel.sv
module dma_reload_channel
    import dmarl_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int CW        = 16,
    parameter int GROUP_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          nmi,
    input  logic          addr_err,
    output logic          xfer_end
);

    logic       master, chan, reload, te, te_set;
    logic       src_wr, dst_wr, cnt_wr, abort, misaligned;
    xfer_size_e size;
    logic [1:0] ptr_lo, dst_lo;

    dmarl_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .ctrl_bits (cfg_wdata[CTRL_BITS-1:0]),
        .nmi_i     (nmi),
        .te_set_i  (te_set),
        .master_o  (master),
        .chan_o    (chan),
        .reload_o  (reload),
        .size_o    (size),
        .te_o      (te),
        .src_wr_o  (src_wr),
        .dst_wr_o  (dst_wr),
        .cnt_wr_o  (cnt_wr),
        .abort_o   (abort)
    );

    dmarl_align u_align (
        .src_lo       (ptr_lo),
        .dst_lo       (dst_lo),
        .size_i       (size),
        .misaligned_o (misaligned)
    );

    dmarl_seq #(
        .AW        (AW),
        .DW        (DW),
        .CW        (CW),
        .GROUP_LEN (GROUP_LEN)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_i     (master),
        .chan_i       (chan),
        .reload_i     (reload),
        .size_i       (size),
        .te_i         (te),
        .src_wr_i     (src_wr),
        .dst_wr_i     (dst_wr),
        .cnt_wr_i     (cnt_wr),
        .wdata_i      (cfg_wdata),
        .abort_i      (abort),
        .aerr_i       (addr_err),
        .misaligned_i (misaligned),
        .mem_ack_i    (mem_ack),
        .mem_rdata_i  (mem_rdata),
        .mem_req_o    (mem_req),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .ptr_lo_o     (ptr_lo),
        .dst_lo_o     (dst_lo),
        .te_set_o     (te_set)
    );

    assign mem_size = size;
    assign xfer_end = te;

endmodule

// File: rtl/dmarl_checker.sv
module dmarl_checker
    import dmarl_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [2:0]    cfg_sel,
    input logic          teclr_bit,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_size,
    input logic          mem_ack,
    input logic          nmi,
    input logic          addr_err,
    input logic          xfer_end
);

    // R2: a pending request is held unchanged until acknowledged
    p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !nmi && !addr_err && !cfg_we)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R2: an acknowledged read is followed by the write cycle
    p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && !nmi && !addr_err && !cfg_we)
        |=> (mem_req && mem_we));

    // R5: no request while the end flag is raised
    p_quiet_on_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |-> !mem_req);

    // R6: end flag only drops through a control write with the clear bit
    p_end_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && !(cfg_we && (cfg_sel == SEL_CTRL) && teclr_bit))
        |=> xfer_end);

    // R7: 16-bit requests are even
    p_half_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (mem_size == 2'd1)) |-> !mem_addr[0]);

    // R7: 32-bit requests are on a four-byte boundary
    p_word_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_size[1]) |-> (mem_addr[1:0] == 2'b00));

    // R8: reported address error ends the transfer
    p_err_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && addr_err && !nmi && !cfg_we) |=> xfer_end);

    // R9: NMI silences the memory port
    p_nmi_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> !mem_req);

endmodule

bind dma_reload_channel dmarl_checker #(.AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .teclr_bit (cfg_wdata[4]),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_ack   (mem_ack),
    .nmi       (nmi),
    .addr_err  (addr_err),
    .xfer_end  (xfer_end)
);

// File: tb/dma_reload_channel_tb_top.sv
`timescale 1ns/1ps
module dma_reload_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        mem_req, mem_we, xfer_end;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        nmi = 1'b0;
    logic        addr_err = 1'b0;

    always #2 clk = ~clk;

    dma_reload_channel dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .nmi(nmi),
        .addr_err(addr_err), .xfer_end(xfer_end)
    );

    int tests = 0;
    int fails = 0;

    // behavioural reference state
    logic [31:0] m_src, m_saved, m_dst, m_rbuf;
    int  m_cnt = 0, m_grp = 0, m_phase = 0, m_size = 0;
    bit  m_reload = 0, m_chan = 0, m_master = 0, m_te = 0;
    int  skip_te = 0;
    int  obs_wr = 0, obs_rd = 0;
    logic [7:0] lfsr = 8'hA7;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    function automatic int step_of(input int s);
        return (s == 0) ? 1 : (s == 1) ? 2 : 4;
    endfunction

    function automatic bit m_halt();
        return m_te || !m_master || !m_chan || (m_cnt == 0);
    endfunction

    function automatic bit m_misal();
        logic [1:0] mk;
        mk = (m_size == 0) ? 2'b00 : (m_size == 1) ? 2'b01 : 2'b11;
        return ((m_src[1:0] | m_dst[1:0]) & mk) != 2'b00;
    endfunction

    function automatic logic [31:0] ctrlw(input bit ch, input bit rl, input int sz, input bit clr);
        return {27'd0, clr, 2'(sz), rl, ch};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // One clock: compare against the model, then drive the next handshake.
    task automatic tick(input bit allow);
        bit a;
        @(negedge clk);
        cfg_we   = 1'b0;
        nmi      = 1'b0;
        addr_err = 1'b0;
        if (skip_te > 0) skip_te--;
        else chk(xfer_end == m_te, "R6", "end flag vs model", {31'd0, xfer_end}, {31'd0, m_te});
        if (m_halt()) chk(!mem_req, "R5", "request while halted", {31'd0, mem_req}, 32'd0);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        a = allow && mem_req && (lfsr[1:0] != 2'b00);
        mem_ack   = a;
        mem_rdata = pat(mem_addr);
        if (a) begin
            chk(mem_size == 2'(m_size), "R3", "size code", {30'd0, mem_size}, 32'(m_size));
            if (m_phase == 0) begin
                chk(!mem_we, "R2", "read phase", {31'd0, mem_we}, 32'd0);
                chk(mem_addr == m_src, "R4", "source address", mem_addr, m_src);
                m_rbuf  = pat(m_src);
                m_phase = 1;
                obs_rd++;
            end else begin
                chk(mem_we, "R2", "write phase", {31'd0, mem_we}, 32'd1);
                chk(mem_addr == m_dst, "R3", "fixed destination", mem_addr, m_dst);
                chk(mem_wdata == m_rbuf, "R2", "write data", mem_wdata, m_rbuf);
                m_phase = 0;
                obs_wr++;
                m_cnt--;
                if (m_reload && m_grp == 3) begin
                    m_src = m_saved;
                    m_grp = 0;
                end else begin
                    m_src = m_src + 32'(step_of(m_size));
                    m_grp = (m_grp + 1) % 4;
                end
                if (m_cnt == 0) begin
                    m_te  = 1;
                    m_grp = 0;
                end
            end
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        tick(0);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        m_phase = 0; m_grp = 0;
        case (sel)
            3'd0: begin m_src = d; m_saved = d; end
            3'd1: m_dst = d;
            3'd2: m_cnt = int'(d[15:0]);
            3'd3: begin
                m_chan = d[0]; m_reload = d[1]; m_size = int'(d[3:2]);
                if (d[4]) m_te = 0;
            end
            default: m_master = d[0];
        endcase
        if (!m_halt() && m_misal()) begin
            m_te = 1;
            skip_te = 2;
        end
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input int n,
                         input int sz, input bit rl);
        wr(3'd0, s);
        wr(3'd1, d);
        wr(3'd2, 32'(n));
        wr(3'd3, ctrlw(1'b1, rl, sz, 1'b1));
        wr(3'd4, 32'd1);
    endtask

    task automatic run_to_end();
        int g = 0;
        while (!m_te && g < 4000) begin tick(1); g++; end
        tick(0); tick(0);
    endtask

    task automatic run_writes(input int target);
        int g = 0;
        while (obs_wr < target && !m_te && g < 4000) begin tick(1); g++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) tick(0);
        // R1: quiet after reset
        chk(!mem_req, "R1", "request after reset", {31'd0, mem_req}, 32'd0);
        chk(!xfer_end, "R1", "end flag after reset", {31'd0, xfer_end}, 32'd0);

        // R3/R5: byte transfers, no reload, odd count
        w0 = obs_wr;
        setup(32'h100, 32'h2000, 5, 0, 1'b0);
        run_to_end();
        chk(obs_wr - w0 == 5, "R5", "transfers for count 5", 32'(obs_wr - w0), 32'd5);
        chk(xfer_end, "R5", "end flag at zero", {31'd0, xfer_end}, 32'd1);

        // R6: flag holds across idle time and a control write without clear
        repeat (10) tick(1);
        wr(3'd3, ctrlw(1'b1, 1'b0, 0, 1'b0));
        repeat (5) tick(1);
        chk(xfer_end, "R6", "flag after non-clearing write", {31'd0, xfer_end}, 32'd1);
        chk(obs_wr - w0 == 5, "R6", "no transfer while flagged", 32'(obs_wr - w0), 32'd5);

        // R4: 16-bit reload, count 8
        w0 = obs_wr;
        setup(32'h200, 32'h2100, 8, 1, 1'b1);
        run_to_end();
        chk(obs_wr - w0 == 8, "R4", "16-bit reload transfers", 32'(obs_wr - w0), 32'd8);

        // R4/R3: 32-bit reload, count 12
        w0 = obs_wr;
        setup(32'h300, 32'h2200, 12, 2, 1'b1);
        run_to_end();
        chk(obs_wr - w0 == 12, "R4", "32-bit reload transfers", 32'(obs_wr - w0), 32'd12);

        // R5: reload with count not a multiple of four
        w0 = obs_wr;
        setup(32'h340, 32'h2240, 6, 0, 1'b1);
        run_to_end();
        chk(obs_wr - w0 == 6, "R5", "stop at zero with count 6", 32'(obs_wr - w0), 32'd6);

        // R7: misaligned source for 16-bit, misaligned destination for 32-bit
        w0 = obs_rd;
        setup(32'h201, 32'h2300, 4, 1, 1'b0);
        repeat (6) tick(1);
        chk(xfer_end, "R7", "flag on odd half source", {31'd0, xfer_end}, 32'd1);
        chk(obs_rd == w0, "R7", "no read on odd source", 32'(obs_rd - w0), 32'd0);
        setup(32'h400, 32'h2302, 4, 3, 1'b0);
        repeat (6) tick(1);
        chk(xfer_end, "R7", "flag on misaligned word dest", {31'd0, xfer_end}, 32'd1);
        chk(obs_rd == w0, "R7", "no read on misaligned dest", 32'(obs_rd - w0), 32'd0);

        // R8/R10: address error parked in a read, then resume
        w0 = obs_wr;
        setup(32'h400, 32'h3000, 8, 2, 1'b1);
        run_writes(w0 + 2);
        tick(0); tick(0);
        chk(mem_req && !mem_we, "R8", "parked in read", {31'd0, mem_req}, 32'd1);
        tick(0);
        addr_err = 1'b1;
        m_te = 1; m_phase = 0; m_grp = 0;
        repeat (4) tick(1);
        chk(xfer_end, "R8", "flag after address error", {31'd0, xfer_end}, 32'd1);
        chk(obs_wr - w0 == 2, "R8", "count kept at error", 32'(obs_wr - w0), 32'd2);
        wr(3'd3, ctrlw(1'b1, 1'b1, 2, 1'b1));
        run_to_end();
        chk(obs_wr - w0 == 8, "R10", "remaining count after error", 32'(obs_wr - w0), 32'd8);

        // R9/R10: channel enable cleared mid-group, then restored
        w0 = obs_wr;
        setup(32'h500, 32'h3100, 8, 1, 1'b1);
        run_writes(w0 + 3);
        tick(0);
        wr(3'd3, ctrlw(1'b0, 1'b1, 1, 1'b0));
        repeat (6) tick(1);
        chk(!mem_req, "R9", "idle with channel off", {31'd0, mem_req}, 32'd0);
        wr(3'd3, ctrlw(1'b1, 1'b1, 1, 1'b0));
        run_to_end();
        chk(obs_wr - w0 == 8, "R10", "remaining count after disable", 32'(obs_wr - w0), 32'd8);

        // R9: NMI in the write phase clears master enable
        w0 = obs_wr;
        setup(32'h600, 32'h3200, 8, 0, 1'b1);
        begin
            int g = 0;
            while (!(obs_wr - w0 == 1 && m_phase == 1) && g < 4000) begin tick(1); g++; end
        end
        tick(0);
        chk(mem_req && mem_we, "R9", "parked in write", {31'd0, mem_we}, 32'd1);
        tick(0);
        nmi = 1'b1;
        m_master = 0; m_phase = 0; m_grp = 0;
        repeat (8) tick(1);
        chk(!mem_req, "R9", "silent after NMI", {31'd0, mem_req}, 32'd0);
        chk(obs_wr - w0 == 1, "R9", "write cancelled by NMI", 32'(obs_wr - w0), 32'd1);
        wr(3'd4, 32'd1);
        run_to_end();
        chk(obs_wr - w0 == 8, "R10", "remaining count after NMI", 32'(obs_wr - w0), 32'd8);

        summary();
        $finish;
    end

endmodule